// File: doc/BRIEF.md
# Call/Return Stack Control Sequencer

This block carries out the control-transfer operations of a small 8-bit processor whose program counter and stack pointer are 16 bits wide. The operations are absolute jump, relative jump, call, return, return that re-enables interrupts, restart to a fixed vector, and jump to the address held in the HL register pair. Instruction fetch and the ALU sit outside the block. A parent pipeline pulses `start` with the operation code, the condition code, the restart vector number, the current flags and HL. The sequencer then reads operand bytes and stack bytes through a byte-wide memory port, writes return addresses to the stack, and updates its own program counter and stack pointer.

The memory port answers reads in the same cycle. `mem_rdata` must reflect `mem_addr` combinationally while `mem_rd` is high, and a write takes effect at the clock edge that ends the `mem_wr` cycle. Each operation spends a fixed number of work cycles, set by its kind and by whether its condition holds. `done` rises in the cycle after the last work cycle. In that cycle the sequencer is idle again and can accept the next `start`.

Top module: `xfer_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0x0100 and `sp` becomes 0xFFFE (parameter defaults). `done`, `ie_set`, `mem_rd` and `mem_wr` are low.
- R2: `cond` selects the test. Code 0 always holds. Code 1 needs Z=1, code 2 needs C=1, code 3 needs Z=0 and code 4 needs C=0. Codes 5 to 7 always hold. The flags are taken from the cycle in which `start` is accepted, and later changes to them have no effect.
- R3: Absolute jump (`op`=0) reads the low byte at `pc` and then the high byte at `pc`+1. When taken, `pc` becomes {high,low} and one idle cycle follows, for 3 work cycles. When not taken, `pc` advances by 2 after 2 work cycles.
- R4: Relative jump (`op`=1) reads one byte at `pc`. When taken, `pc` becomes `pc`+1 plus the sign-extended byte and one idle cycle follows, for 2 work cycles. When not taken, `pc` becomes `pc`+1 after 1 work cycle.
- R5: Call (`op`=2) reads a 16-bit target like R3. When taken, it writes the high byte of the return address (`pc`+2) at `sp`-1 and then the low byte at `sp`-2. It then idles one cycle, leaves `sp` lower by 2 and loads the target, for 5 work cycles. When not taken, it makes no write, advances `pc` by 2, and takes 2 work cycles.
- R6: Return (`op`=3) with `cond`=0 reads the low byte at `sp` and the high byte at `sp`+1. It loads `pc` from them, raises `sp` by 2 and idles one cycle, for 3 work cycles. With any nonzero `cond`, one internal cycle comes first. If the condition fails the operation ends there, after 1 work cycle, with no change.
- R7: Return with interrupt enable (`op`=4) ignores `cond` and behaves as the unconditional return. It raises `ie_set` together with `done`.
- R8: Restart (`op`=5) writes the `pc` low byte at `sp`-2 and then the high byte at `sp`-1. It lowers `sp` by 2, loads `pc` with `vec`×8, and idles one cycle, for 3 work cycles.
- R9: Jump to HL (`op`=6) loads `pc` from `hl` with no memory access, and `done` follows in the next cycle. Code 7 does nothing except raise `done` in the next cycle.
- R10: `done` is high for exactly one cycle per operation, in the cycle after its last work cycle. In that cycle `pc` and `sp` hold the final values and no memory strobe is active. `mem_rd` and `mem_wr` are never high together.
- R11: A `start` that arrives while an operation is in progress, before its `done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation |
| op | input | 3 | Operation code (R3 to R9) |
| cond | input | 3 | Condition code (R2) |
| vec | input | 3 | Restart vector number |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| hl | input | 16 | HL register pair value |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_rd` |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| done | output | 1 | Operation finished |
| ie_set | output | 1 | Interrupt-enable request |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
The two functions that can share a cycle are the completion of one operation and the acceptance of the next. `done` is raised in an idle cycle that also samples `start`. In most of the stimulus, the next operation is issued exactly in the previous one's `done` cycle. A reference model predicts every cycle's strobes, address, write data and final registers, so an operation that loses its first cycle, or that starts from stale `pc`/`sp`, shows up as a mismatch in the very next cycle. The counter case is provoked separately: a jump-to-HL request is injected while a call or return is still busy, and the model expects the request to leave no trace.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 2 * BYTE_W;
    localparam int OP_W      = 3;
    localparam int CC_W      = 3;
    localparam int VEC_W     = 3;
    localparam int VEC_SHIFT = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [OP_W-1:0] {
        OP_JP   = 3'd0,
        OP_JR   = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4,
        OP_RST  = 3'd5,
        OP_JHL  = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    localparam logic [CC_W-1:0] CC_ALWAYS = 3'd0;
    localparam logic [CC_W-1:0] CC_Z      = 3'd1;
    localparam logic [CC_W-1:0] CC_C      = 3'd2;
    localparam logic [CC_W-1:0] CC_NZ     = 3'd3;
    localparam logic [CC_W-1:0] CC_NC     = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IMM_LO,
        ST_IMM_HI,
        ST_IMM_REL,
        ST_COND,
        ST_WR_A,
        ST_WR_B,
        ST_POP_LO,
        ST_POP_HI,
        ST_STALL
    } state_e;

    typedef struct packed {
        op_e              op;
        logic             taken;
        logic [VEC_W-1:0] vec;
    } cmd_t;

    function automatic logic cond_met(logic [CC_W-1:0] cc, logic z, logic c);
        case (cc)
            CC_Z:    return z;
            CC_C:    return c;
            CC_NZ:   return !z;
            CC_NC:   return !c;
            default: return 1'b1;
        endcase
    endfunction

    function automatic addr_t sext(byte_t b);
        return {{(ADDR_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

endpackage

// File: rtl/xfer_cond.sv
module xfer_cond
    import xfer_pkg::*;
(
    input  logic [CC_W-1:0] cc,
    input  logic            z,
    input  logic            c,
    output logic            taken
);
    assign taken = cond_met(cc, z, c);
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import xfer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  op_e             new_op,
    input  logic [CC_W-1:0] new_cc,
    input  cmd_t            cmd,
    output state_e          state,
    output logic            finish
);
    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    case (new_op)
                        OP_JP, OP_CALL: nxt = ST_IMM_LO;
                        OP_JR:          nxt = ST_IMM_REL;
                        OP_RET:         nxt = (new_cc != CC_ALWAYS) ? ST_COND : ST_POP_LO;
                        OP_RETI:        nxt = ST_POP_LO;
                        OP_RST:         nxt = ST_WR_A;
                        default:        nxt = ST_IDLE;
                    endcase
                end
            end
            ST_IMM_LO:  nxt = ST_IMM_HI;
            ST_IMM_HI: begin
                if (!cmd.taken)              nxt = ST_IDLE;
                else if (cmd.op == OP_CALL)  nxt = ST_WR_A;
                else                         nxt = ST_STALL;
            end
            ST_IMM_REL: nxt = cmd.taken ? ST_STALL : ST_IDLE;
            ST_COND:    nxt = cmd.taken ? ST_POP_LO : ST_IDLE;
            ST_WR_A:    nxt = ST_WR_B;
            ST_WR_B:    nxt = ST_STALL;
            ST_POP_LO:  nxt = ST_POP_HI;
            ST_POP_HI:  nxt = ST_STALL;
            ST_STALL:   nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    assign finish = ((state != ST_IDLE) || accept) && (nxt == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/xfer_port.sv
module xfer_port
    import xfer_pkg::*;
(
    input  state_e state,
    input  logic   is_call,
    input  addr_t  pc,
    input  addr_t  sp,
    output logic   rd,
    output logic   wr,
    output addr_t  addr,
    output byte_t  wdata
);
    addr_t sp_m1, sp_m2;
    byte_t pc_hi, pc_lo;

    assign sp_m1 = sp - addr_t'(1);
    assign sp_m2 = sp - addr_t'(2);
    assign pc_hi = pc[ADDR_W-1:BYTE_W];
    assign pc_lo = pc[BYTE_W-1:0];

    always_comb begin
        rd    = 1'b0;
        wr    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (state)
            ST_IMM_LO, ST_IMM_HI, ST_IMM_REL: begin
                rd   = 1'b1;
                addr = pc;
            end
            ST_WR_A: begin
                wr    = 1'b1;
                addr  = is_call ? sp_m1 : sp_m2;
                wdata = is_call ? pc_hi : pc_lo;
            end
            ST_WR_B: begin
                wr    = 1'b1;
                addr  = is_call ? sp_m2 : sp_m1;
                wdata = is_call ? pc_lo : pc_hi;
            end
            ST_POP_LO: begin
                rd   = 1'b1;
                addr = sp;
            end
            ST_POP_HI: begin
                rd   = 1'b1;
                addr = sp + addr_t'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter logic [15:0] PC_RESET = 16'h0100,
    parameter logic [15:0] SP_RESET = 16'hFFFE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [OP_W-1:0]      op,
    input  logic [CC_W-1:0]      cond,
    input  logic [VEC_W-1:0]     vec,
    input  logic                 flag_z,
    input  logic                 flag_c,
    input  logic [ADDR_W-1:0]    hl,
    input  logic [BYTE_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BYTE_W-1:0]    mem_wdata,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 done,
    output logic                 ie_set,
    output logic [ADDR_W-1:0]    pc,
    output logic [ADDR_W-1:0]    sp
);
    addr_t  pc_q, sp_q, tgt_q;
    byte_t  lo_q;
    cmd_t   cmd_q;
    state_e state;
    logic   accept, finish, taken_now, done_q, ie_q;
    op_e    op_in;
    addr_t  imm_word, vec_addr;

    assign op_in    = op_e'(op);
    assign accept   = start && (state == ST_IDLE);
    assign imm_word = {mem_rdata, lo_q};
    assign vec_addr = addr_t'(cmd_q.vec) << VEC_SHIFT;

    xfer_cond i_cond (
        .cc    (cond),
        .z     (flag_z),
        .c     (flag_c),
        .taken (taken_now)
    );

    xfer_fsm i_fsm (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .new_op (op_in),
        .new_cc (cond),
        .cmd    (cmd_q),
        .state  (state),
        .finish (finish)
    );

    xfer_port i_port (
        .state   (state),
        .is_call (cmd_q.op == OP_CALL),
        .pc      (pc_q),
        .sp      (sp_q),
        .rd      (mem_rd),
        .wr      (mem_wr),
        .addr    (mem_addr),
        .wdata   (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= PC_RESET;
            sp_q   <= SP_RESET;
            tgt_q  <= '0;
            lo_q   <= '0;
            cmd_q  <= '{op: OP_NONE, taken: 1'b0, vec: '0};
            done_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            done_q <= finish;
            ie_q   <= finish && (state != ST_IDLE) && (cmd_q.op == OP_RETI);
            if (accept) begin
                cmd_q <= '{op: op_in, taken: taken_now, vec: vec};
                if (op_in == OP_JHL) pc_q <= hl;
            end
            case (state)
                ST_IMM_LO: begin
                    lo_q <= mem_rdata;
                    pc_q <= pc_q + addr_t'(1);
                end
                ST_IMM_HI: begin
                    tgt_q <= imm_word;
                    if (cmd_q.taken && cmd_q.op == OP_JP) pc_q <= imm_word;
                    else                                  pc_q <= pc_q + addr_t'(1);
                end
                ST_IMM_REL: begin
                    if (cmd_q.taken) pc_q <= pc_q + addr_t'(1) + sext(mem_rdata);
                    else             pc_q <= pc_q + addr_t'(1);
                end
                ST_WR_B: begin
                    sp_q <= sp_q - addr_t'(2);
                    pc_q <= (cmd_q.op == OP_CALL) ? tgt_q : vec_addr;
                end
                ST_POP_LO: lo_q <= mem_rdata;
                ST_POP_HI: begin
                    pc_q <= imm_word;
                    sp_q <= sp_q + addr_t'(2);
                end
                default: ;
            endcase
        end
    end

    assign pc     = pc_q;
    assign sp     = sp_q;
    assign done   = done_q;
    assign ie_set = ie_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk
    import xfer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] sp,
    input logic              done,
    input logic              ie_set
);
    p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R5 and R8: stack writes land just below the unchanged SP
    p_wr_addr_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr == sp - ADDR_W'(1) || mem_addr == sp - ADDR_W'(2)));

    // R3, R4 and R6: reads hit the operand at PC or the stack top
    p_rd_addr_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr == pc || mem_addr == sp || mem_addr == sp + ADDR_W'(1)));

    p_sp_step_r6: assert property (@(posedge clk) disable iff (rst)
        (sp != $past(sp)) |-> (sp == $past(sp) + ADDR_W'(2) || sp == $past(sp) - ADDR_W'(2)));

    p_wr_pair_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr) |=> mem_wr);

    p_ie_done_r7: assert property (@(posedge clk) disable iff (rst)
        ie_set |-> done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_rd && !mem_wr));
endmodule

bind xfer_seq xfer_seq_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .pc       (pc),
    .sp       (sp),
    .done     (done),
    .ie_set   (ie_set)
);

// File: tb/test_xfer_seq.sv
module test_xfer_seq;

    // 20 time-unit period: 50 MHz with 1 ns units
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd7, cond = 3'd0, vec = 3'd0;
    logic        flag_z = 1'b0, flag_c = 1'b0;
    logic [15:0] hl = 16'h0000;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc, sp;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, done, ie_set;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xfer_seq i_xfer_seq (
        .clk(clk), .rst(rst), .start(start), .op(op), .cond(cond), .vec(vec),
        .flag_z(flag_z), .flag_c(flag_c), .hl(hl), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .done(done), .ie_set(ie_set), .pc(pc), .sp(sp)
    );

    function automatic logic [7:0] init_byte(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // memory seen by the design
    logic [7:0] mem [1024];
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_byte(i);
        end else if (mem_wr) begin
            mem[mem_addr[9:0]] <= mem_wdata;
        end
    end

    // reference model state
    logic [7:0]  m_mem [1024];
    logic [15:0] m_pc = 16'h0100;
    logic [15:0] m_sp = 16'hFFFE;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        dn;
        logic        ie;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [15:0] pc;
        logic [15:0] sp;
    } exp_t;

    exp_t  q_exp [$];
    string q_tag [$];

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] rdm(logic [15:0] a);
        return m_mem[a[9:0]];
    endfunction

    function automatic logic model_taken(logic [2:0] c, logic z, logic fc);
        case (c)
            3'd1: return z;
            3'd2: return fc;
            3'd3: return !z;
            3'd4: return !fc;
            default: return 1'b1;
        endcase
    endfunction

    task automatic put(input logic rd, input logic wr, input logic [15:0] a,
                       input logic [7:0] d, input logic dn, input logic ie,
                       input string tag);
        exp_t e;
        e.rd = rd; e.wr = wr; e.dn = dn; e.ie = ie;
        e.addr = a; e.wd = d; e.pc = m_pc; e.sp = m_sp;
        if (wr) m_mem[a[9:0]] = d;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // compare every cycle, a quarter period after the active edge
    always @(posedge clk) begin
        #5;
        if (!rst && !finished) begin
            if (q_exp.size() > 0) begin
                exp_t  e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                chk(t, "mem_rd", 32'(mem_rd), 32'(e.rd));
                chk(t, "mem_wr", 32'(mem_wr), 32'(e.wr));
                if (e.rd || e.wr) chk(t, "mem_addr", 32'(mem_addr), 32'(e.addr));
                if (e.wr)         chk(t, "mem_wdata", 32'(mem_wdata), 32'(e.wd));
                chk(t, "done", 32'(done), 32'(e.dn));
                chk(t, "ie_set", 32'(ie_set), 32'(e.ie));
                if (e.dn) begin
                    chk(t, "pc", 32'(pc), 32'(e.pc));
                    chk(t, "sp", 32'(sp), 32'(e.sp));
                end
            end else begin
                chk("R10", "idle done", 32'(done), 32'd0);
                chk("R10", "idle strobes", 32'({mem_rd, mem_wr}), 32'd0);
            end
        end
    end

    // Call just after a falling edge; returns at the falling edge inside the done cycle.
    task automatic issue(input logic [2:0] o, input logic [2:0] c, input logic [2:0] v,
                         input logic z, input logic fc, input logic [15:0] h,
                         input string tag, input int poke);
        logic [7:0]  lo, hi;
        logic [15:0] a;
        logic        tk;
        int          n0, n;
        n0 = q_exp.size();
        op = o; cond = c; vec = v; flag_z = z; flag_c = fc; hl = h; start = 1'b1;
        tk = model_taken(c, z, fc);
        case (o)
            3'd0: begin
                lo = rdm(m_pc); hi = rdm(m_pc + 16'd1);
                put(1, 0, m_pc, 0, 0, 0, tag);
                put(1, 0, m_pc + 16'd1, 0, 0, 0, tag);
                if (tk) begin m_pc = {hi, lo}; put(0, 0, 0, 0, 0, 0, tag); end
                else m_pc = m_pc + 16'd2;
            end
            3'd1: begin
                lo = rdm(m_pc);
                put(1, 0, m_pc, 0, 0, 0, tag);
                a = m_pc + 16'd1;
                if (tk) begin m_pc = a + {{8{lo[7]}}, lo}; put(0, 0, 0, 0, 0, 0, tag); end
                else m_pc = a;
            end
            3'd2: begin
                lo = rdm(m_pc); hi = rdm(m_pc + 16'd1);
                put(1, 0, m_pc, 0, 0, 0, tag);
                put(1, 0, m_pc + 16'd1, 0, 0, 0, tag);
                a = m_pc + 16'd2;
                if (tk) begin
                    put(0, 1, m_sp - 16'd1, a[15:8], 0, 0, tag);
                    put(0, 1, m_sp - 16'd2, a[7:0], 0, 0, tag);
                    put(0, 0, 0, 0, 0, 0, tag);
                    m_sp = m_sp - 16'd2;
                    m_pc = {hi, lo};
                end else m_pc = a;
            end
            3'd3, 3'd4: begin
                if (o == 3'd4) tk = 1'b1;
                if (o == 3'd3 && c != 3'd0) put(0, 0, 0, 0, 0, 0, tag);
                if (tk) begin
                    lo = rdm(m_sp); hi = rdm(m_sp + 16'd1);
                    put(1, 0, m_sp, 0, 0, 0, tag);
                    put(1, 0, m_sp + 16'd1, 0, 0, 0, tag);
                    put(0, 0, 0, 0, 0, 0, tag);
                    m_pc = {hi, lo};
                    m_sp = m_sp + 16'd2;
                end
            end
            3'd5: begin
                put(0, 1, m_sp - 16'd2, m_pc[7:0], 0, 0, tag);
                put(0, 1, m_sp - 16'd1, m_pc[15:8], 0, 0, tag);
                put(0, 0, 0, 0, 0, 0, tag);
                m_sp = m_sp - 16'd2;
                m_pc = 16'(v) * 16'd8;
            end
            3'd6: m_pc = h;
            default: ;
        endcase
        put(0, 0, 0, 0, 1, (o == 3'd4), tag);
        n = q_exp.size() - n0;
        @(negedge clk);
        start = 1'b0;
        // inputs move away after acceptance: flags must have been captured (R2)
        flag_z = ~z; flag_c = ~fc; cond = ~c; op = 3'd7;
        for (int k = 0; k < n - 1; k++) begin
            if (k == poke) begin
                start = 1'b1; op = 3'd6; hl = 16'hBEEF;
            end
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) m_mem[i] = init_byte(i);
        repeat (3) @(negedge clk);
        chk("R1", "reset pc", 32'(pc), 32'h0100);
        chk("R1", "reset sp", 32'(sp), 32'hFFFE);
        chk("R1", "reset done", 32'({done, ie_set}), 32'd0);
        chk("R1", "reset strobes", 32'({mem_rd, mem_wr}), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        issue(3'd0, 3'd0, 3'd0, 0, 0, 16'h0, "R3", -1);
        issue(3'd0, 3'd1, 3'd0, 0, 0, 16'h0, "R2", -1);
        issue(3'd0, 3'd1, 3'd0, 1, 0, 16'h0, "R2", -1);
        issue(3'd6, 3'd0, 3'd0, 0, 0, 16'h0120, "R9", -1);
        issue(3'd1, 3'd0, 3'd0, 0, 0, 16'h0, "R4", -1);
        issue(3'd1, 3'd4, 3'd0, 0, 1, 16'h0, "R4", -1);
        issue(3'd1, 3'd3, 3'd0, 0, 0, 16'h0, "R2", -1);
        @(negedge clk);
        issue(3'd1, 3'd2, 3'd0, 0, 1, 16'h0, "R4", -1);
        issue(3'd6, 3'd0, 3'd0, 0, 0, 16'h0200, "R9", -1);
        issue(3'd1, 3'd0, 3'd0, 0, 0, 16'h0, "R4", -1);
        issue(3'd6, 3'd0, 3'd0, 0, 0, 16'h0140, "R9", -1);
        issue(3'd2, 3'd0, 3'd0, 0, 0, 16'h0, "R5", -1);
        issue(3'd3, 3'd1, 3'd0, 0, 0, 16'h0, "R6", -1);
        issue(3'd3, 3'd0, 3'd0, 0, 0, 16'h0, "R6", -1);
        issue(3'd2, 3'd2, 3'd0, 0, 0, 16'h0, "R5", -1);
        issue(3'd2, 3'd3, 3'd0, 0, 1, 16'h0, "R5", -1);
        issue(3'd3, 3'd4, 3'd0, 1, 0, 16'h0, "R6", -1);
        repeat (2) @(negedge clk);
        issue(3'd2, 3'd5, 3'd0, 0, 0, 16'h0, "R2", -1);
        issue(3'd4, 3'd2, 3'd0, 0, 0, 16'h0, "R7", -1);
        issue(3'd5, 3'd0, 3'd7, 0, 0, 16'h0, "R8", -1);
        issue(3'd3, 3'd0, 3'd0, 0, 0, 16'h0, "R6", -1);
        issue(3'd5, 3'd0, 3'd0, 1, 1, 16'h0, "R8", -1);
        issue(3'd5, 3'd0, 3'd3, 0, 0, 16'h0, "R8", -1);
        issue(3'd7, 3'd0, 3'd0, 0, 0, 16'h0, "R9", -1);
        issue(3'd4, 3'd0, 3'd0, 0, 0, 16'h0, "R7", -1);
        issue(3'd6, 3'd0, 3'd0, 0, 0, 16'h0300, "R10", -1);
        issue(3'd2, 3'd0, 3'd0, 0, 0, 16'h0, "R11", 1);
        issue(3'd3, 3'd0, 3'd0, 0, 0, 16'h0, "R11", 0);
        issue(3'd1, 3'd0, 3'd0, 0, 0, 16'h0, "R11", 0);
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule